// File: doc/BRIEF.md
# Subsampled Rotation and Address Sequencer

This block drives the memory addresses and the lane rotator of a partially parallel decoder for quasi-cyclic LDPC codes. The code is built on groups of `M` logical lanes, but only `P = M/L` physical lanes exist, so each logical group is spread over `L` subgroups. Logical index `i` sits in subgroup `i mod L` at physical lane `floor(i/L)`. Memories are therefore `L` times deeper and `L` times narrower than in a layout with `M` physical lanes.

An external table holds one base shift and one base row per group entry. Both are written for the full `M`-lane view. The sequencer walks the table entry by entry and, for each entry, steps through the `L` subgroups. For each step it derives the physical read row, the physical write row and the rotation amount, so the table does not grow with `L`. In bit-node runs the read row simply counts up, and results are rotated right before the write. In check-node runs the rows come from the table, and results are rotated left. The rotator is a log-depth mux network that rotates modulo `P`, including values of `P` that are not a power of two.

Top module: `subrot_seq`

## Requirements
- R1: While reset is held and right after it is released, `busy` and `out_valid` are 0.
- R2: A run started with a count of `n` gives exactly `n*L` consecutive cycles with `out_valid` high. Step `k` belongs to table entry `k/L` and subgroup `k mod L`. `tbl_idx` carries the entry index while the step is being formed.
- R3: In a bit-node run (`cn_mode` = 0), `out_rd_addr` equals the step number `k`, which rises by one each valid cycle.
- R4: In a check-node run (`cn_mode` = 1), `out_rd_addr` equals `tbl_addr*L + g`, where `g` is the subgroup.
- R5: In a bit-node run with base shift `s` and subgroup `g`, logical lane 0 of the subgroup moves to logical index `(g+s) mod M`. The target subgroup is that index mod `L`, and `out_rot` is that index divided by `L`, as a right rotation.
- R6: In a check-node run, logical lane 0 of subgroup `g` moves to `d = (g-s) mod M`. The target subgroup is `d mod L`, and `out_rot` is `(P - d/L) mod P`, as a left rotation.
- R7: `out_wr_addr` equals `a*L + t`, where `a` is the base row and `t` is the target subgroup. The base row is the entry index in bit-node runs and `tbl_addr` in check-node runs. Read and write rows therefore lie in the same block of `L` rows.
- R8: `wr_data_out` lane `j` (bits `j*W +: W`) equals `wr_data_in` lane `(j - out_rot) mod P` when `out_left` = 0, and lane `(j + out_rot) mod P` when `out_left` = 1.
- R9: `start` has no effect while a run is in progress, and a start with a count of 0 begins no run.
- R10: Valid outputs appear one cycle after the table entry is read. The cycle after `start` is sampled has `busy` high and `out_valid` low.
- R11: `out_left` equals the `cn_mode` captured at the start of the run and stays constant for the whole run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle |
| cn_mode | input | 1 | 0 = bit-node run, 1 = check-node run |
| entry_count | input | AW | Number of table entries in the run |
| tbl_idx | output | AW | Table entry being read |
| tbl_shift | input | SW | Base shift of the entry, 0 to M-1 |
| tbl_addr | input | AW | Base row of the entry |
| busy | output | 1 | Run in progress |
| out_valid | output | 1 | Address and rotation outputs are valid |
| out_left | output | 1 | Rotation direction: 1 = left |
| out_rd_addr | output | AW+LW | Physical read row |
| out_wr_addr | output | AW+LW | Physical write row |
| out_rot | output | RW | Rotation amount, 0 to P-1 |
| wr_data_in | input | P*W | Lane messages to rotate |
| wr_data_out | output | P*W | Rotated lane messages |

## Verification
Several properties are checked on every cycle. `out_valid` follows `busy` by one cycle, and the first valid cycle follows the rise of `busy`. The rotation amount stays below `P`. Read and write rows share a row block. The bit-node read row counts up, and the direction holds steady within a run. The exact subgroup and rotation arithmetic for each shift, the rows taken from the table, and the lane movement of the data can only be shown by the bench. It compares every step of random and corner-case tables against an independent logical-index model. Ignored starts and zero-count starts are also shown only by the bench scenarios.

// File: rtl/subrot_pkg.sv
package subrot_pkg;
  // target subgroup after a right move by s
  function automatic int tgt_right(int g, int s, int l);
    return (g + s) % l;
  endfunction

  function automatic int rot_right(int g, int s, int l, int p);
    return ((g + s) / l) % p;
  endfunction

  // target subgroup after a left move by s
  function automatic int tgt_left(int g, int s, int l);
    int rs;
    rs = s % l;
    return (g >= rs) ? (g - rs) : (g - rs + l);
  endfunction

  function automatic int rot_left(int g, int s, int l, int p);
    int rs;
    rs = s % l;
    return ((s / l) + ((g < rs) ? 1 : 0)) % p;
  endfunction
endpackage

// File: rtl/seq_walker.sv
module seq_walker #(
  parameter int L  = 4,
  parameter int AW = 8,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cn_mode,
  input  logic [AW-1:0] entry_count,
  output logic          busy,
  output logic          run_cn,
  output logic [AW-1:0] ent_idx,
  output logic [LW-1:0] sub_idx,
  output logic          step_first,
  output logic          step_last
);
  logic [AW-1:0] cnt_q;
  logic          sub_wrap;

  assign sub_wrap   = (sub_idx == LW'(L - 1));
  assign step_last  = busy && sub_wrap && (ent_idx == cnt_q - AW'(1));
  assign step_first = busy && (ent_idx == '0) && (sub_idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      run_cn  <= 1'b0;
      ent_idx <= '0;
      sub_idx <= '0;
      cnt_q   <= '0;
    end else if (!busy) begin
      if (start && (entry_count != '0)) begin
        busy    <= 1'b1;
        run_cn  <= cn_mode;
        cnt_q   <= entry_count;
        ent_idx <= '0;
        sub_idx <= '0;
      end
    end else if (sub_wrap) begin
      sub_idx <= '0;
      if (step_last) busy <= 1'b0;
      else           ent_idx <= ent_idx + AW'(1);
    end else begin
      sub_idx <= sub_idx + LW'(1);
    end
  end
endmodule

// File: rtl/step_mapper.sv
module step_mapper
  import subrot_pkg::*;
#(
  parameter int L   = 4,
  parameter int P   = 90,
  parameter int AW  = 8,
  parameter int LW  = 2,
  parameter int SW  = 9,
  parameter int RW  = 7,
  parameter int OAW = AW + LW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           busy,
  input  logic           run_cn,
  input  logic [AW-1:0]  ent_idx,
  input  logic [LW-1:0]  sub_idx,
  input  logic [SW-1:0]  tbl_shift,
  input  logic [AW-1:0]  tbl_addr,
  output logic           out_valid,
  output logic           out_left,
  output logic [OAW-1:0] out_rd_addr,
  output logic [OAW-1:0] out_wr_addr,
  output logic [RW-1:0]  out_rot
);
  logic [AW-1:0]  base_row;
  logic [OAW-1:0] row_blk;
  int             gi, si, tgt, rot;

  always_comb begin
    base_row = run_cn ? tbl_addr : ent_idx;
    gi       = int'(sub_idx);
    si       = int'(tbl_shift);
    if (run_cn) begin
      tgt = tgt_left(gi, si, L);
      rot = rot_left(gi, si, L, P);
    end else begin
      tgt = tgt_right(gi, si, L);
      rot = rot_right(gi, si, L, P);
    end
    row_blk = OAW'(base_row) * OAW'(L);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_left    <= 1'b0;
      out_rd_addr <= '0;
      out_wr_addr <= '0;
      out_rot     <= '0;
    end else begin
      out_valid <= busy;
      if (busy) begin
        out_left    <= run_cn;
        out_rd_addr <= row_blk + OAW'(sub_idx);
        out_wr_addr <= row_blk + OAW'(tgt);
        out_rot     <= RW'(rot);
      end
    end
  end
endmodule

// File: rtl/lane_rotator.sv
module lane_rotator #(
  parameter int P  = 90,
  parameter int W  = 5,
  parameter int RW = 7
) (
  input  logic [P*W-1:0] din,
  input  logic [RW-1:0]  amt,
  input  logic           left,
  output logic [P*W-1:0] dout
);
  logic [W-1:0] st [RW+1][P];

  for (genvar k = 0; k < P; k++) begin : g_in
    assign st[0][k] = din[k*W +: W];
    assign dout[k*W +: W] = st[RW][k];
  end

  for (genvar b = 0; b < RW; b++) begin : g_stage
    localparam int STEP = (1 << b) % P;
    for (genvar k = 0; k < P; k++) begin : g_lane
      localparam int SRC_R = (k + P - STEP) % P;
      localparam int SRC_L = (k + STEP) % P;
      assign st[b+1][k] = !amt[b] ? st[b][k]
                        : (left ? st[b][SRC_L] : st[b][SRC_R]);
    end
  end
endmodule

// File: rtl/subrot_seq.sv
module subrot_seq #(
  parameter int M  = 360,
  parameter int L  = 4,
  parameter int W  = 5,
  parameter int AW = 8,
  localparam int P   = M / L,
  localparam int LW  = (L > 1) ? $clog2(L) : 1,
  localparam int SW  = $clog2(M),
  localparam int RW  = (P > 1) ? $clog2(P) : 1,
  localparam int OAW = AW + LW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           cn_mode,
  input  logic [AW-1:0]  entry_count,
  output logic [AW-1:0]  tbl_idx,
  input  logic [SW-1:0]  tbl_shift,
  input  logic [AW-1:0]  tbl_addr,
  output logic           busy,
  output logic           out_valid,
  output logic           out_left,
  output logic [OAW-1:0] out_rd_addr,
  output logic [OAW-1:0] out_wr_addr,
  output logic [RW-1:0]  out_rot,
  input  logic [P*W-1:0] wr_data_in,
  output logic [P*W-1:0] wr_data_out
);
  logic          run_cn;
  logic [AW-1:0] ent_idx;
  logic [LW-1:0] sub_idx;
  logic          step_first;
  logic          step_last;

  seq_walker #(.L(L), .AW(AW), .LW(LW)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .cn_mode(cn_mode),
    .entry_count(entry_count), .busy(busy), .run_cn(run_cn),
    .ent_idx(ent_idx), .sub_idx(sub_idx),
    .step_first(step_first), .step_last(step_last)
  );

  assign tbl_idx = ent_idx;

  step_mapper #(.L(L), .P(P), .AW(AW), .LW(LW), .SW(SW), .RW(RW), .OAW(OAW)) u_map (
    .clk(clk), .rst_n(rst_n), .busy(busy), .run_cn(run_cn),
    .ent_idx(ent_idx), .sub_idx(sub_idx),
    .tbl_shift(tbl_shift), .tbl_addr(tbl_addr),
    .out_valid(out_valid), .out_left(out_left),
    .out_rd_addr(out_rd_addr), .out_wr_addr(out_wr_addr), .out_rot(out_rot)
  );

  lane_rotator #(.P(P), .W(W), .RW(RW)) u_rot (
    .din(wr_data_in), .amt(out_rot), .left(out_left), .dout(wr_data_out)
  );
endmodule

// File: rtl/subrot_seq_chk.sv
module subrot_seq_chk #(
  parameter int L   = 4,
  parameter int P   = 90,
  parameter int OAW = 10,
  parameter int RW  = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           step_first,
  input logic           out_valid,
  input logic           out_left,
  input logic [OAW-1:0] out_rd_addr,
  input logic [OAW-1:0] out_wr_addr,
  input logic [RW-1:0]  out_rot
);
  // R1: idle after reset
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !busy && !out_valid);
  // R2: valid tracks busy one cycle later
  p_valid_on_r2: assert property (@(posedge clk) disable iff (!rst_n) busy |=> out_valid);
  p_valid_off_r2: assert property (@(posedge clk) disable iff (!rst_n) !busy |=> !out_valid);
  // R10: first step is formed in the first busy cycle, output one cycle later
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> step_first ##1 $rose(out_valid));
  // R3: bit-node read row counts up
  p_bn_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_left && $past(out_valid))
      |-> out_rd_addr == $past(out_rd_addr) + OAW'(1));
  // R5: rotation amount in range
  p_rot_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_rot) < P);
  // R7: read and write rows share a row block
  p_same_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_rd_addr / OAW'(L)) == (out_wr_addr / OAW'(L)));
  // R11: direction constant inside a run
  p_dir_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> $stable(out_left));
endmodule

bind subrot_seq subrot_seq_chk #(.L(L), .P(P), .OAW(OAW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .step_first(step_first),
  .out_valid(out_valid), .out_left(out_left),
  .out_rd_addr(out_rd_addr), .out_wr_addr(out_wr_addr), .out_rot(out_rot)
);

// File: tb/subrot_seq_test.sv
module subrot_seq_test;
  localparam int PERIOD = 10;
  localparam int M = 360, L = 4, W = 5, AW = 8;
  localparam int P = M / L, LW = 2, SW = 9, RW = 7, OAW = AW + LW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cn_mode = 1'b0;
  logic [AW-1:0]  entry_count = '0;
  logic [AW-1:0]  tbl_idx;
  logic [SW-1:0]  tbl_shift;
  logic [AW-1:0]  tbl_addr;
  logic           busy, out_valid, out_left;
  logic [OAW-1:0] out_rd_addr, out_wr_addr;
  logic [RW-1:0]  out_rot;
  logic [P*W-1:0] wr_data_in = '0, wr_data_out;

  logic [SW-1:0] tab_s [256];
  logic [AW-1:0] tab_a [256];
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  assign tbl_shift = tab_s[tbl_idx];
  assign tbl_addr  = tab_a[tbl_idx];

  always #(PERIOD/2) clk = ~clk;

  subrot_seq #(.M(M), .L(L), .W(W), .AW(AW)) uut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected move of logical lane 0 of subgroup g
  function automatic int dest_idx(bit cn, int g, int s);
    return cn ? (g - s + M) % M : (g + s) % M;
  endfunction

  function automatic int exp_rot(bit cn, int d);
    return cn ? (P - d / L) % P : d / L;
  endfunction

  task automatic check_data(bit cn, int r);
    int bad = -1;
    for (int j = 0; j < P; j++) begin
      int src = cn ? (j + r) % P : (j - r + P) % P;
      if (wr_data_out[j*W +: W] != wr_data_in[src*W +: W]) bad = j;
    end
    chk(bad < 0, "R8 lane data", bad, -1);
  endtask

  task automatic run(bit cn, int cnt, bit poke);
    @(negedge clk);
    start = 1'b1; cn_mode = cn; entry_count = AW'(cnt);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", busy, 1);
    chk(out_valid == 1'b0, "R10 no output before table read", out_valid, 0);
    for (int k = 0; k < cnt * L; k++) begin
      int e = k / L, g = k % L, s, a, d;
      @(negedge clk);
      s = int'(tab_s[e]);
      a = cn ? int'(tab_a[e]) : e;
      d = dest_idx(cn, g, s);
      chk(out_valid == 1'b1, "R2 valid step", out_valid, 1);
      chk(out_left == cn, "R11 direction", out_left, cn);
      if (cn) chk(int'(out_rd_addr) == a * L + g, "R4 check-node read row", out_rd_addr, a * L + g);
      else    chk(int'(out_rd_addr) == k, "R3 bit-node read row", out_rd_addr, k);
      chk(int'(out_wr_addr) == a * L + d % L, "R7 write row", out_wr_addr, a * L + d % L);
      chk(int'(out_rot) == exp_rot(cn, d), cn ? "R6 left rotation" : "R5 right rotation",
          out_rot, exp_rot(cn, d));
      for (int j = 0; j < P; j++) wr_data_in[j*W +: W] = W'($urandom);
      #1 check_data(cn, exp_rot(cn, d));
      // R9: a second start mid-run with the other mode is ignored
      if (poke) start = (k == 1);
      if (poke && k == 1) cn_mode = ~cn;
    end
    start = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 run length", out_valid, 0);
    chk(busy == 1'b0, "R9 no restart from mid-run start", busy, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin
      tab_s[i] = SW'($urandom % M);
      tab_a[i] = AW'($urandom);
    end
    // corner shifts: zero, top, within a subgroup, exact multiples of L
    tab_s[0] = 9'd0;   tab_s[1] = 9'd359; tab_s[2] = 9'd3;
    tab_s[3] = 9'd4;   tab_s[4] = 9'd1;   tab_s[5] = 9'd358;
    tab_s[6] = 9'd356; tab_a[0] = 8'd255; tab_a[1] = 8'd0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && out_valid == 1'b0, "R1 reset idle", {busy, out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && out_valid == 1'b0, "R1 idle after reset", {busy, out_valid}, 0);
    // R9: zero count does not start a run
    start = 1'b1; cn_mode = 1'b0; entry_count = '0;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0 && out_valid == 1'b0, "R9 zero count ignored", {busy, out_valid}, 0);
    run(1'b0, 7, 1'b1);
    run(1'b1, 7, 1'b1);
    for (int t = 0; t < 6; t++) begin
      for (int i = 0; i < 20; i++) begin
        tab_s[i] = SW'($urandom % M);
        tab_a[i] = AW'($urandom);
      end
      run(t[0], 1 + ($urandom % 12), 1'b0);
    end
    run(1'b1, 1, 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule